// File: doc/BRIEF.md
# I2C Master Clock and Data-Hold Timing Generator

This block produces the SCL and SDA drive waveform for an I2C master, one byte at a time. The SCL low time and the SCL high time come from two independent divider inputs, so the duty cycle is not tied to 50%. A shared power-of-two prescale exponent stretches both phases together. Each SDA change is held back by a programmable number of system-clock cycles after SCL falls, which keeps a data transition on SDA well clear of the SCL falling edge, where a receiver could read it as a repeated START.

A byte is handed over on a valid/ready request port and is shifted out MSB first, one bit per SCL cycle. The next byte may be accepted in the last cycle of the previous byte's final high phase, so bytes follow with no gap. The divider, prescale and hold inputs are sampled at the start of every SCL low phase and held for that whole bit. A change made mid-bit therefore never shortens or stretches a phase that has already started. When the requested hold would not let SDA settle before SCL rises again, it is clamped and a setup-error flag is raised. Both line outputs are release enables (1 = line released). Framing, acknowledge handling, arbitration and slave clock stretching are left to other logic.

Top module: `i2c_scl_sda_timer`

## Requirements
- R1: In reset and while idle, scl_rel_o and sda_rel_o are both 1, req_ready_o is 1, and scl_fall_o, scl_rise_o, byte_done_o and setup_err_o are 0.
- R2: Each SCL low phase (scl_rel_o = 0) lasts exactly lo_div_i * 2^prescale_i + 4 system-clock cycles.
- R3: Each SCL high phase inside a transfer (scl_rel_o = 1) lasts exactly hi_div_i * 2^prescale_i + 4 cycles.
- R4: sda_rel_o changes exactly H cycles after the clock edge on which SCL falls, where H is the hold value in effect (H = 0 means the same edge). During a byte, sda_rel_o never changes while SCL is high.
- R5: When hold_i exceeds (low length − 1), H is clamped to low length − 1 and setup_err_o is 1 while that bit is driven. Otherwise setup_err_o is 0.
- R6: lo_div_i, hi_div_i, prescale_i and hold_i are sampled only when a low phase starts. A change during a phase affects only the phases that begin after it.
- R7: The byte on req_data_i is driven MSB first, with sda_rel_o equal to the bit value, over 8 SCL cycles. byte_done_o pulses for one cycle after the eighth high phase ends.
- R8: scl_fall_o is 1 only in the first cycle of each low phase, and scl_rise_o is 1 only in the first cycle of each high phase.
- R9: req_ready_o is 1 only when idle or in the last cycle of a byte's final high phase. A byte accepted in that cycle starts its low phase on the next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_div_i | input | DIV_W | SCL low-phase divider |
| hi_div_i | input | DIV_W | SCL high-phase divider |
| prescale_i | input | PS_W | Shared prescale exponent for both phases |
| hold_i | input | HOLD_W | SDA hold delay after SCL falls, in cycles |
| req_valid_i | input | 1 | Byte request valid |
| req_data_i | input | BYTE_W | Byte to drive, MSB first |
| req_ready_o | output | 1 | Byte request accepted when high together with valid |
| scl_rel_o | output | 1 | SCL release enable (0 = pull low) |
| sda_rel_o | output | 1 | SDA release enable (0 = pull low) |
| scl_fall_o | output | 1 | First cycle of an SCL low phase |
| scl_rise_o | output | 1 | First cycle of an SCL high phase |
| byte_done_o | output | 1 | One-cycle pulse after the last bit of a byte |
| setup_err_o | output | 1 | Hold clamped for the bit being driven |

## Verification
The assertions check on every cycle that both lines are released while idle, that the phase counter stays inside the sampled low length, that the sampled lengths do not move during a low phase, that the clamped hold always fits inside the low phase, that SDA stays still through a high phase, and that the strobes line up with SCL edges. Only the bench scenarios can show that the measured low time, high time and SDA delay match the divider formula for several settings. The same goes for the delay being zero when hold is zero, for a mid-phase divider write reaching only later phases, and for back-to-back bytes arriving bit-exact with no gap cycle.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/i2c_tg_cfg.sv
// Samples the timing inputs at each low-phase start and derives phase lengths
// and the clamped SDA hold value.
module i2c_tg_cfg #(
  parameter int DIV_W  = 8,
  parameter int PS_W   = 3,
  parameter int HOLD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DIV_W-1:0]  lo_div_i,
  input  logic [DIV_W-1:0]  hi_div_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [CNT_W-1:0]  low_len_o,
  output logic [CNT_W-1:0]  high_len_o,
  output logic [CNT_W-1:0]  hold_o,
  output logic              clamp_o,
  output logic              hold_zero_nxt_o
);
  localparam int CMP_W = (HOLD_W > CNT_W) ? HOLD_W : CNT_W;
  localparam logic [CNT_W-1:0] PH_EXTRA = CNT_W'(4);

  logic [CNT_W-1:0] lo_len_c, hi_len_c, hold_max_c, hold_eff_c;
  logic             clamp_c;
  logic [CNT_W-1:0] lo_len_q, hi_len_q, hold_q;
  logic             clamp_q;

  always_comb begin
    lo_len_c   = (CNT_W'(lo_div_i) << ps_i) + PH_EXTRA;
    hi_len_c   = (CNT_W'(hi_div_i) << ps_i) + PH_EXTRA;
    hold_max_c = lo_len_c - CNT_W'(1);
    clamp_c    = CMP_W'(hold_i) > CMP_W'(hold_max_c);
    hold_eff_c = clamp_c ? hold_max_c : CNT_W'(hold_i);
    hold_zero_nxt_o = (hold_eff_c == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len_q <= PH_EXTRA;
      hi_len_q <= PH_EXTRA;
      hold_q   <= '0;
      clamp_q  <= 1'b0;
    end else if (load_i) begin
      lo_len_q <= lo_len_c;
      hi_len_q <= hi_len_c;
      hold_q   <= hold_eff_c;
      clamp_q  <= clamp_c;
    end else if (clear_i) begin
      clamp_q  <= 1'b0;
    end
  end

  assign low_len_o  = lo_len_q;
  assign high_len_o = hi_len_q;
  assign hold_o     = hold_q;
  assign clamp_o    = clamp_q;

  // R5: the stored hold always lands before the end of the low phase
  p_hold_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q < lo_len_q);
endmodule

// File: rtl/i2c_tg_phase_ctrl.sv
// Phase sequencer: idle / SCL low / SCL high, cycle counter and bit shifter.
module i2c_tg_phase_ctrl
  import i2c_tg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [BYTE_W-1:0] req_data_i,
  input  logic [CNT_W-1:0]  low_len_i,
  input  logic [CNT_W-1:0]  high_len_i,
  output logic              req_ready_o,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              enter_low_o,
  output logic              enter_high_o,
  output logic              byte_end_o,
  output logic              go_idle_o,
  output logic              cur_bit_o,
  output logic              nxt_bit_o
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              low_end, high_end, last_bit, byte_end, accept, advance;

  always_comb begin
    low_end  = (phase_q == PH_LOW)  && (cnt_q == low_len_i  - CNT_W'(1));
    high_end = (phase_q == PH_HIGH) && (cnt_q == high_len_i - CNT_W'(1));
    last_bit = (idx_q == LAST_IDX);
    byte_end = high_end && last_bit;
    req_ready_o = (phase_q == PH_IDLE) || byte_end;
    accept   = req_valid_i && req_ready_o;
    advance  = high_end && !last_bit;

    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (accept) phase_d = PH_LOW;
      end
      PH_LOW: begin
        if (low_end) begin
          phase_d = PH_HIGH;
          cnt_d   = '0;
        end
      end
      PH_HIGH: begin
        if (high_end) begin
          cnt_d   = '0;
          phase_d = (last_bit && !accept) ? PH_IDLE : PH_LOW;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase

    data_d = data_q;
    idx_d  = idx_q;
    if (accept) begin
      data_d = req_data_i;
      idx_d  = '0;
    end else if (advance) begin
      data_d = data_q << 1;
      idx_d  = idx_q + IDX_W'(1);
    end

    enter_low_o  = accept || advance;
    enter_high_o = low_end;
    byte_end_o   = byte_end;
    go_idle_o    = byte_end && !accept;
    cur_bit_o    = data_q[BYTE_W-1];
    nxt_bit_o    = accept  ? req_data_i[BYTE_W-1] :
                   advance ? data_q[BYTE_W-2] : data_q[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R2: the low-phase counter never runs past the sampled low length
  p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_len_i));
  // R6: the sampled lengths are held through a low phase
  p_len_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && $past(phase_q) == PH_LOW) |->
      ($stable(low_len_i) && $stable(high_len_i)));
endmodule

// File: rtl/i2c_tg_sda_hold.sv
// SDA update scheduler: moves each data change H cycles after SCL falls.
module i2c_tg_sda_hold
  import i2c_tg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             enter_low_i,
  input  logic             hold_zero_nxt_i,
  input  logic             go_idle_i,
  input  logic             cur_bit_i,
  input  logic             nxt_bit_i,
  output logic             sda_rel_o
);
  logic sda_q, sda_d;
  logic due;

  always_comb begin
    due   = (phase_i == PH_LOW) && (hold_i != '0) &&
            (cnt_i == hold_i - CNT_W'(1));
    sda_d = sda_q;
    if (go_idle_i)                         sda_d = 1'b1;
    else if (enter_low_i && hold_zero_nxt_i) sda_d = nxt_bit_i;
    else if (due)                          sda_d = cur_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b1;
    else        sda_q <= sda_d;
  end

  assign sda_rel_o = sda_q;

  // R4: SDA is quiet while SCL stays high
  p_sda_quiet_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_HIGH && $past(phase_i) == PH_HIGH) |-> $stable(sda_q));
endmodule

// File: rtl/i2c_scl_sda_timer.sv
module i2c_scl_sda_timer
  import i2c_tg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PS_W   = 3,
  parameter int HOLD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  lo_div_i,
  input  logic [DIV_W-1:0]  hi_div_i,
  input  logic [PS_W-1:0]   prescale_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              req_valid_i,
  input  logic [BYTE_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              scl_rel_o,
  output logic              sda_rel_o,
  output logic              scl_fall_o,
  output logic              scl_rise_o,
  output logic              byte_done_o,
  output logic              setup_err_o
);
  localparam int CNT_W = DIV_W + (1 << PS_W);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  phase_e           phase;
  logic [CNT_W-1:0] cnt, low_len, high_len, hold_eff;
  logic             enter_low, enter_high, byte_end, go_idle;
  logic             cur_bit, nxt_bit, hold_zero_nxt, clamp;
  logic             scl_q, scl_d, fall_q, rise_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  i2c_tg_cfg #(
    .DIV_W(DIV_W), .PS_W(PS_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk_i), .rst_n(rst_n), .load_i(enter_low), .clear_i(go_idle),
    .lo_div_i(lo_div_i), .hi_div_i(hi_div_i), .ps_i(prescale_i),
    .hold_i(hold_i), .low_len_o(low_len), .high_len_o(high_len),
    .hold_o(hold_eff), .clamp_o(clamp), .hold_zero_nxt_o(hold_zero_nxt)
  );

  i2c_tg_phase_ctrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk_i), .rst_n(rst_n), .req_valid_i(req_valid_i),
    .req_data_i(req_data_i), .low_len_i(low_len), .high_len_i(high_len),
    .req_ready_o(req_ready_o), .phase_o(phase), .cnt_o(cnt),
    .enter_low_o(enter_low), .enter_high_o(enter_high),
    .byte_end_o(byte_end), .go_idle_o(go_idle),
    .cur_bit_o(cur_bit), .nxt_bit_o(nxt_bit)
  );

  i2c_tg_sda_hold #(.CNT_W(CNT_W)) u_sda (
    .clk(clk_i), .rst_n(rst_n), .phase_i(phase), .cnt_i(cnt),
    .hold_i(hold_eff), .enter_low_i(enter_low),
    .hold_zero_nxt_i(hold_zero_nxt), .go_idle_i(go_idle),
    .cur_bit_i(cur_bit), .nxt_bit_i(nxt_bit), .sda_rel_o(sda_rel_o)
  );

  always_comb begin
    scl_d = scl_q;
    if (enter_low)       scl_d = 1'b0;
    else if (enter_high) scl_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      scl_q  <= scl_d;
      fall_q <= enter_low;
      rise_q <= enter_high;
      done_q <= byte_end;
    end
  end

  assign scl_rel_o   = scl_q;
  assign scl_fall_o  = fall_q;
  assign scl_rise_o  = rise_q;
  assign byte_done_o = done_q;
  assign setup_err_o = clamp;

  // R1: both lines released whenever the sequencer is idle
  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (scl_rel_o && sda_rel_o));
  // R8: fall strobe marks a real SCL falling edge
  p_fall_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    scl_fall_o |-> (!scl_rel_o && $past(scl_rel_o)));
  // R8: rise strobe marks a real SCL rising edge
  p_rise_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    scl_rise_o |-> (scl_rel_o && !$past(scl_rel_o)));
  // R9: the request port is closed while SCL is low
  p_ready_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase == PH_LOW) |-> !req_ready_o);
endmodule

// File: tb/tb_i2c_scl_sda_timer.sv
module tb_i2c_scl_sda_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] lo_div, hi_div;
  logic [2:0] ps;
  logic [15:0] hold;
  logic       req_valid;
  logic [7:0] req_data;
  logic       req_ready, scl, sda, sfall, srise, bdone, serr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // monitor state
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int low_run = 0, high_run = 0;
  int lo_min, lo_max, hi_min, hi_max, dly_min, dly_max;
  int n_low, n_high, n_dly, first_low, sda_hi_chg, strobe_err, done_cnt, n_fall;
  logic seen_low, setup_seen;
  logic [15:0] rx_word;

  always #2.5 clk = ~clk;

  i2c_scl_sda_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .lo_div_i(lo_div), .hi_div_i(hi_div),
    .prescale_i(ps), .hold_i(hold), .req_valid_i(req_valid),
    .req_data_i(req_data), .req_ready_o(req_ready), .scl_rel_o(scl),
    .sda_rel_o(sda), .scl_fall_o(sfall), .scl_rise_o(srise),
    .byte_done_o(bdone), .setup_err_o(serr)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk); #1;
    lo_min = 1 << 30; lo_max = -1; hi_min = 1 << 30; hi_max = -1;
    dly_min = 1 << 30; dly_max = -1;
    n_low = 0; n_high = 0; n_dly = 0; first_low = -1; sda_hi_chg = 0;
    strobe_err = 0; done_cnt = 0; n_fall = 0; seen_low = 1'b0;
    setup_seen = 1'b0; rx_word = '0;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (sfall !== (!scl && prev_scl)) strobe_err++;
      if (srise !== (scl && !prev_scl)) strobe_err++;
      if (bdone) done_cnt++;
      if (!scl) begin
        if (serr) setup_seen = 1'b1;
        low_run = prev_scl ? 1 : low_run + 1;
        if (prev_scl) begin
          n_fall++;
          if (seen_low) begin
            n_high++;
            if (high_run < hi_min) hi_min = high_run;
            if (high_run > hi_max) hi_max = high_run;
          end
          seen_low = 1'b1;
        end
        if (sda !== prev_sda) begin
          n_dly++;
          if (low_run - 1 < dly_min) dly_min = low_run - 1;
          if (low_run - 1 > dly_max) dly_max = low_run - 1;
        end
      end else begin
        if (!prev_scl) begin
          n_low++;
          if (first_low < 0) first_low = low_run;
          if (low_run < lo_min) lo_min = low_run;
          if (low_run > lo_max) lo_max = low_run;
          rx_word = {rx_word[14:0], sda};
          high_run = 1;
        end else begin
          high_run++;
          if (sda !== prev_sda && !req_ready) sda_hi_chg++;
        end
      end
      prev_scl = scl;
      prev_sda = sda;
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drop_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int guard = 0;
    while (done_cnt < n && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Single byte with a given setting: checks R2, R3, R4, R5, R7, R8
  task automatic run_byte(input string tag, input int lo, input int hi,
                          input int p, input int h, input logic [7:0] d);
    int l_len, h_len, h_eff, clamped;
    l_len = lo * (1 << p) + 4;
    h_len = hi * (1 << p) + 4;
    clamped = (h > l_len - 1) ? 1 : 0;
    h_eff = clamped ? l_len - 1 : h;
    @(negedge clk);
    lo_div = 8'(lo); hi_div = 8'(hi); ps = 3'(p); hold = 16'(h);
    mon_clear();
    send(d);
    drop_req();
    wait_done(1);
    $display("scenario %s", tag);
    chk("R2", "low min",  lo_min, l_len);
    chk("R2", "low max",  lo_max, l_len);
    chk("R3", "high min", hi_min, h_len);
    chk("R3", "high max", hi_max, h_len);
    chk("R4", "sda delay min", dly_min, h_eff);
    chk("R4", "sda delay max", dly_max, h_eff);
    chk("R4", "sda moves while scl high", sda_hi_chg, 0);
    chk("R5", "setup flag", setup_seen, clamped);
    chk("R7", "received byte", rx_word[7:0], d);
    chk("R7", "byte done pulses", done_cnt, 1);
    chk("R8", "falls", n_fall, 8);
    chk("R8", "strobe mismatches", strobe_err, 0);
    chk("R1", "idle scl", scl, 1);
    chk("R1", "idle sda", sda, 1);
    chk("R5", "setup flag idle", serr, 0);
  endtask

  // R6: divider written mid-phase affects only later phases
  task automatic mid_change();
    @(negedge clk);
    lo_div = 8'd10; hi_div = 8'd10; ps = 3'd0; hold = 16'd2;
    mon_clear();
    send(8'h55);
    drop_req();
    repeat (5) @(negedge clk);
    lo_div = 8'd20;
    wait_done(1);
    chk("R6", "first low unchanged", first_low, 14);
    chk("R6", "later lows new", lo_max, 24);
    chk("R6", "low min", lo_min, 14);
    chk("R6", "high unchanged", hi_max, 14);
    chk("R7", "received byte", rx_word[7:0], 8'h55);
  endtask

  // R9: two bytes back to back with no idle gap
  task automatic back_to_back();
    @(negedge clk);
    lo_div = 8'd4; hi_div = 8'd2; ps = 3'd1; hold = 16'd5;
    mon_clear();
    send(8'hA5);
    @(negedge clk);
    chk("R9", "ready closed mid byte", req_ready, 0);
    req_data = 8'h3C;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    drop_req();
    wait_done(2);
    chk("R9", "bytes done", done_cnt, 2);
    chk("R9", "high phases between", n_high, 15);
    chk("R9", "high min no gap", hi_min, 8);
    chk("R9", "high max no gap", hi_max, 8);
    chk("R2", "low len", lo_max, 12);
    chk("R7", "first byte", rx_word[15:8], 8'hA5);
    chk("R7", "second byte", rx_word[7:0], 8'h3C);
    chk("R4", "sda delay", dly_max, 5);
    chk("R4", "sda moves while scl high", sda_hi_chg, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_data = '0;
    lo_div = '0; hi_div = '0; ps = '0; hold = '0;
    mon_clear();
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", "reset scl", scl, 1);
    chk("R1", "reset sda", sda, 1);
    chk("R1", "reset fall strobe", sfall, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle ready", req_ready, 1);
    chk("R1", "idle done", bdone, 0);
    chk("R1", "idle setup", serr, 0);
    chk("R1", "idle rise strobe", srise, 0);

    run_byte("symmetric", 10, 10, 0, 3, 8'h55);
    run_byte("asym_prescale", 12, 5, 2, 13, 8'h55);
    run_byte("hold_zero", 3, 3, 0, 0, 8'h55);
    run_byte("clamped", 2, 2, 0, 20, 8'h55);
    run_byte("edge_of_window", 2, 1, 0, 5, 8'h96);
    mid_change();
    back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule